// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Stall Unit

This block holds the hazard logic of a five-stage in-order pipeline whose stages are split by the IF/ID, ID/EX, EX/MEM and MEM/WB registers. It reads the 32-bit instruction sitting in IF/ID and decodes which registers it reads and which register it will write. It keeps a small record of that information as each instruction moves down through ID/EX, EX/MEM and MEM/WB. From this record it chooses, for each of the two ALU operands of the instruction now in ID/EX, whether the value comes from the register file, from the ALU result held in EX/MEM, or from the write-back value held in MEM/WB.

Forwarding cannot resolve one case. When a load is in ID/EX and the instruction in IF/ID reads the register that load writes, the unit asserts the PC hold and the IF/ID hold for one cycle. It also raises a NOP-insert flag so that the surrounding pipeline loads an all-zero control word into ID/EX in place of the held instruction. The unit records that bubble as an entry that reads and writes nothing. With this logic, software does not need to pad dependent instructions with NOPs.

The register file is assumed to write in the first half of a cycle and to read in the second half. A producer that has already left MEM/WB therefore needs no forwarding.

Top module: `hzu_top`

## Requirements
- R1: Instruction fields are the opcode at bits 31:28, the first source (S) at 27:25, the second source or I-type destination (T) at 24:22, the R-type destination (D) at 21:19, and the immediate at 15:0. The opcode values are: 0 no-op, 1 register ALU (reads S and T, writes D), 2 immediate ALU (reads S, writes T), 3 load (reads S, writes T), 4 store (reads S and T), 5 branch (reads S and T), and 6 jump. Values 6 to 15 read and write no register.
- R2: While reset is low, and in the first cycle after it, both forwarding selects are 00 and all three stall outputs are 0. Reset discards any recorded load, so a load seen before reset never causes a stall afterwards.
- R3: The forwarding select encoding is 00 for the register file, 01 for the EX/MEM ALU result and 10 for the MEM/WB value. Operand A select is 01 when the instruction in EX/MEM writes the S register of the instruction in ID/EX.
- R4: Operand A select is 10 when the instruction in MEM/WB writes that S register and the instruction in EX/MEM does not.
- R5: When both EX/MEM and MEM/WB write the needed register, the select is 01, because the younger result wins.
- R6: Operand B follows the same rules on the T register, but only for the opcodes that read T (1, 4 and 5). For every other opcode it is 00.
- R7: Only opcodes 1, 2 and 3 produce a forwardable result. Stores, branches, jumps, no-ops and reserved opcodes never cause a non-zero select. For opcodes 2 and 3 the written register is T, never the bits at 21:19.
- R8: When a load is in ID/EX and the IF/ID instruction reads, as S or T, the register the load writes, then pc_hold, ifid_hold and nop_insert are all 1 in that cycle.
- R9: After a stall cycle, the ID/EX record is a bubble. The next cycle therefore shows no stall and both selects at 00, and the held consumer later takes the load value with select 10.
- R10: An IF/ID instruction never stalls on a field it does not read. Jumps, no-ops, reserved opcodes, and an immediate ALU whose T matches the load destination all pass without a stall.
- R11: A register-ALU or immediate-ALU producer followed at once by its consumer causes no stall, and the consumer takes select 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_instr | input | 32 | Instruction held in the IF/ID register |
| fwd_a_sel | output | 2 | Source select for ALU operand A of the ID/EX instruction |
| fwd_b_sel | output | 2 | Source select for ALU operand B of the ID/EX instruction |
| pc_hold | output | 1 | Keep the current PC instead of the incremented one |
| ifid_hold | output | 1 | Keep the IF/ID register contents |
| nop_insert | output | 1 | Load an all-zero control word into ID/EX |

## Verification
The stall outputs depend only on the word presented on ifid_instr and on the recorded ID/EX entry, so they are due in the same cycle that word is presented. A forwarding select is due one rising edge later, once the consumer has moved into ID/EX. The producer is then one stage ahead for select 01 and two stages ahead for select 10, or one stage further when a bubble sits between them. The bench drives each word just after the falling edge and advances its own stage model at the rising edge. It compares the outputs 1 ns after the falling edge, so each expected item is checked in exactly the cycle it belongs to. A stalled word is presented again, and its expectations are computed again, until it is accepted.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned NREG    = 8;
  localparam int unsigned RIDX_W  = $clog2(NREG);

  // field positions inside the instruction word
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 28;
  localparam int RS_LO  = 25;
  localparam int RT_LO  = 22;
  localparam int RD_LO  = 19;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ALU    = 4'd1,
    OP_ALUI   = 4'd2,
    OP_LOAD   = 4'd3,
    OP_STORE  = 4'd4,
    OP_BRANCH = 4'd5,
    OP_JUMP   = 4'd6
  } opc_e;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_e;

  // hazard view of one instruction in ID/EX
  typedef struct packed {
    logic              rd_rs;
    logic              rd_rt;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic              wr;
    logic              ld;
    logic [RIDX_W-1:0] dst;
  } hctl_t;

  // what later stages keep: only the write target
  typedef struct packed {
    logic              wr;
    logic [RIDX_W-1:0] dst;
  } hwr_t;

  // younger producer first, then older, else register file
  function automatic logic [1:0] fwd_pick(
    input logic              need,
    input logic [RIDX_W-1:0] src,
    input logic              near_wr,
    input logic [RIDX_W-1:0] near_dst,
    input logic              far_wr,
    input logic [RIDX_W-1:0] far_dst
  );
    if (need && near_wr && (near_dst == src)) return FWD_EXMEM;
    if (need && far_wr && (far_dst == src))   return FWD_MEMWB;
    return FWD_RF;
  endfunction

  // a writing load whose target is read by the next instruction
  function automatic logic load_use(
    input logic              prod_ld,
    input logic              prod_wr,
    input logic [RIDX_W-1:0] prod_dst,
    input logic              use_s,
    input logic [RIDX_W-1:0] s_idx,
    input logic              use_t,
    input logic [RIDX_W-1:0] t_idx
  );
    return prod_ld && prod_wr &&
           ((use_s && (s_idx == prod_dst)) || (use_t && (t_idx == prod_dst)));
  endfunction

endpackage

// File: rtl/hzu_decode.sv
module hzu_decode
  import hzu_pkg::*;
(
  input  logic [OPC_HI:RD_LO] hdr,
  output hctl_t               ctl
);

  opc_e              op;
  logic [RIDX_W-1:0] f_s;
  logic [RIDX_W-1:0] f_t;
  logic [RIDX_W-1:0] f_d;

  assign op  = opc_e'(hdr[OPC_HI:OPC_LO]);
  assign f_s = hdr[RS_LO +: RIDX_W];
  assign f_t = hdr[RT_LO +: RIDX_W];
  assign f_d = hdr[RD_LO +: RIDX_W];

  always_comb begin
    ctl       = '0;
    ctl.rs    = f_s;
    ctl.rt    = f_t;
    unique case (op)
      OP_ALU: begin
        ctl.rd_rs = 1'b1;
        ctl.rd_rt = 1'b1;
        ctl.wr    = 1'b1;
        ctl.dst   = f_d;
      end
      OP_ALUI: begin
        ctl.rd_rs = 1'b1;
        ctl.wr    = 1'b1;
        ctl.dst   = f_t;
      end
      OP_LOAD: begin
        ctl.rd_rs = 1'b1;
        ctl.wr    = 1'b1;
        ctl.ld    = 1'b1;
        ctl.dst   = f_t;
      end
      OP_STORE, OP_BRANCH: begin
        ctl.rd_rs = 1'b1;
        ctl.rd_rt = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hzu_track.sv
module hzu_track
  import hzu_pkg::*;
#(
  parameter int unsigned LATE_N = 2
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  hctl_t                   in_ctl,
  input  logic                    bubble,
  output hctl_t                   idex,
  output hwr_t [LATE_N-1:0]       late
);

  hctl_t             idex_q;
  hwr_t [LATE_N-1:0] late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q <= '0;
      late_q <= '0;
    end else begin
      idex_q       <= bubble ? hctl_t'('0) : in_ctl;
      late_q[0].wr  <= idex_q.wr;
      late_q[0].dst <= idex_q.dst;
      for (int i = 1; i < int'(LATE_N); i++) begin
        late_q[i] <= late_q[i-1];
      end
    end
  end

  assign idex = idex_q;
  assign late = late_q;

endmodule

// File: rtl/hzu_fwd.sv
module hzu_fwd
  import hzu_pkg::*;
(
  input  logic              need,
  input  logic [RIDX_W-1:0] src,
  input  logic              near_wr,
  input  logic [RIDX_W-1:0] near_dst,
  input  logic              far_wr,
  input  logic [RIDX_W-1:0] far_dst,
  output logic [1:0]        sel
);

  assign sel = fwd_pick(need, src, near_wr, near_dst, far_wr, far_dst);

endmodule

// File: rtl/hzu_ldstall.sv
module hzu_ldstall
  import hzu_pkg::*;
(
  input  logic              prod_ld,
  input  logic              prod_wr,
  input  logic [RIDX_W-1:0] prod_dst,
  input  logic              use_s,
  input  logic [RIDX_W-1:0] s_idx,
  input  logic              use_t,
  input  logic [RIDX_W-1:0] t_idx,
  output logic              stall
);

  assign stall = load_use(prod_ld, prod_wr, prod_dst, use_s, s_idx, use_t, t_idx);

endmodule

// File: rtl/hzu_top.sv
module hzu_top
  import hzu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ifid_instr,
  output logic [1:0]         fwd_a_sel,
  output logic [1:0]         fwd_b_sel,
  output logic               pc_hold,
  output logic               ifid_hold,
  output logic               nop_insert
);

  localparam int unsigned LATE_N = 2;  // EX/MEM, MEM/WB
  localparam int unsigned N_OPND = 2;  // operand A, operand B
  localparam int unsigned NEAR   = 0;
  localparam int unsigned FAR    = LATE_N - 1;

  hctl_t             dec_ctl;
  hctl_t             idex;
  hwr_t [LATE_N-1:0] late;
  logic              unused_low;

  // named internal events for the checker
  logic              stall_evt;
  logic              idx_ld;
  logic              idx_wr;
  logic              idx_rd_rs;
  logic              idx_rd_rt;
  logic [RIDX_W-1:0] idx_rs;
  logic [RIDX_W-1:0] idx_rt;
  logic [RIDX_W-1:0] idx_dst;
  logic              exm_wr;
  logic [RIDX_W-1:0] exm_dst;
  logic              mwb_wr;
  logic [RIDX_W-1:0] mwb_dst;

  logic              need_v [N_OPND];
  logic [RIDX_W-1:0] src_v  [N_OPND];
  logic [1:0]        sel_v  [N_OPND];

  assign unused_low = ^ifid_instr[RD_LO-1:0];

  hzu_decode u_dec (
    .hdr (ifid_instr[OPC_HI:RD_LO]),
    .ctl (dec_ctl)
  );

  hzu_track #(.LATE_N(LATE_N)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_ctl (dec_ctl),
    .bubble (stall_evt),
    .idex   (idex),
    .late   (late)
  );

  assign idx_ld    = idex.ld;
  assign idx_wr    = idex.wr;
  assign idx_rd_rs = idex.rd_rs;
  assign idx_rd_rt = idex.rd_rt;
  assign idx_rs    = idex.rs;
  assign idx_rt    = idex.rt;
  assign idx_dst   = idex.dst;
  assign exm_wr    = late[NEAR].wr;
  assign exm_dst   = late[NEAR].dst;
  assign mwb_wr    = late[FAR].wr;
  assign mwb_dst   = late[FAR].dst;

  hzu_ldstall u_stall (
    .prod_ld  (idx_ld),
    .prod_wr  (idx_wr),
    .prod_dst (idx_dst),
    .use_s    (dec_ctl.rd_rs),
    .s_idx    (dec_ctl.rs),
    .use_t    (dec_ctl.rd_rt),
    .t_idx    (dec_ctl.rt),
    .stall    (stall_evt)
  );

  assign need_v[0] = idx_rd_rs;
  assign src_v[0]  = idx_rs;
  assign need_v[1] = idx_rd_rt;
  assign src_v[1]  = idx_rt;

  for (genvar g = 0; g < int'(N_OPND); g++) begin : g_opnd
    hzu_fwd u_fwd (
      .need     (need_v[g]),
      .src      (src_v[g]),
      .near_wr  (exm_wr),
      .near_dst (exm_dst),
      .far_wr   (mwb_wr),
      .far_dst  (mwb_dst),
      .sel      (sel_v[g])
    );
  end

  assign fwd_a_sel  = sel_v[0];
  assign fwd_b_sel  = sel_v[1];
  assign pc_hold    = stall_evt;
  assign ifid_hold  = stall_evt;
  assign nop_insert = stall_evt;

endmodule

// File: rtl/hzu_chk.sv
module hzu_chk #(
  parameter int unsigned RW = 3
)(
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ifid_opc,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          nop_insert,
  input logic          stall_evt,
  input logic          idx_ld,
  input logic          idx_rd_rt,
  input logic [RW-1:0] idx_rs,
  input logic          exm_wr,
  input logic [RW-1:0] exm_dst
);

  assert_stall_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> idx_ld);

  assert_stall_outs_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold == ifid_hold) && (ifid_hold == nop_insert));

  assert_stall_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> !nop_insert);

  assert_bubble_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (fwd_a_sel == 2'b00) && (fwd_b_sel == 2'b00));

  assert_jump_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ifid_opc == 4'd6) |-> !pc_hold);

  assert_near_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == 2'b01) |-> (exm_wr && (exm_dst == idx_rs)));

  assert_near_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == 2'b10) |-> !(exm_wr && (exm_dst == idx_rs)));

  assert_b_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_sel != 2'b00) |-> idx_rd_rt);

endmodule

bind hzu_top hzu_chk #(.RW(hzu_pkg::RIDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ifid_opc   (ifid_instr[31:28]),
  .fwd_a_sel  (fwd_a_sel),
  .fwd_b_sel  (fwd_b_sel),
  .pc_hold    (pc_hold),
  .ifid_hold  (ifid_hold),
  .nop_insert (nop_insert),
  .stall_evt  (stall_evt),
  .idx_ld     (idx_ld),
  .idx_rd_rt  (idx_rd_rt),
  .idx_rs     (idx_rs),
  .exm_wr     (exm_wr),
  .exm_dst    (exm_dst)
);

// File: tb/hzu_top_tb_top.sv
module hzu_top_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ifid_instr = '0;
  wire  [1:0]  fwd_a_sel;
  wire  [1:0]  fwd_b_sel;
  wire         pc_hold;
  wire         ifid_hold;
  wire         nop_insert;

  always #2.5 clk = ~clk;

  hzu_top dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct { bit r1; bit r2; bit w; bit l; int s1; int s2; int d; } mdl_t;
  typedef struct { int a; int b; bit st; string ta; string tb; string ts; string why; } exp_t;

  exp_t sbq[$];
  mdl_t m_ex, m_mem, m_wb;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // bench-side decode, written from the opcode table in R1
  function automatic mdl_t tb_dec(logic [31:0] w);
    mdl_t m = '{default: 0};
    int op = int'(w >> 28);
    int s  = int'((w >> 25) & 32'h7);
    int t  = int'((w >> 22) & 32'h7);
    int dd = int'((w >> 19) & 32'h7);
    m.s1 = s; m.s2 = t;
    if (op == 1) begin m.r1 = 1; m.r2 = 1; m.w = 1; m.d = dd; end
    if (op == 2) begin m.r1 = 1; m.w = 1; m.d = t; end
    if (op == 3) begin m.r1 = 1; m.w = 1; m.l = 1; m.d = t; end
    if (op == 4 || op == 5) begin m.r1 = 1; m.r2 = 1; end
    return m;
  endfunction

  function automatic int pick(bit need, int src);
    if (!need) return 0;
    if (m_mem.w && m_mem.d == src) return 1;
    if (m_wb.w && m_wb.d == src) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] mk_r(int op, int s, int t, int d);
    return {op[3:0], s[2:0], t[2:0], d[2:0], 19'd0};
  endfunction

  function automatic logic [31:0] mk_i(int op, int s, int t, int imm);
    return {op[3:0], s[2:0], t[2:0], 6'd0, imm[15:0]};
  endfunction

  // driver: present a word, push expectations, repeat while held
  task automatic feed(logic [31:0] w, string why);
    mdl_t c = tb_dec(w);
    bit st;
    exp_t e;
    do begin
      @(negedge clk);
      ifid_instr = w;
      st = m_ex.l && m_ex.w && ((c.r1 && c.s1 == m_ex.d) || (c.r2 && c.s2 == m_ex.d));
      e.a  = pick(m_ex.r1, m_ex.s1);
      e.b  = pick(m_ex.r2, m_ex.s2);
      e.st = st;
      e.ta = (m_ex.r1 && m_mem.w && m_mem.d == m_ex.s1 && m_wb.w && m_wb.d == m_ex.s1) ? "R5" :
             (e.a == 1) ? "R3" : (e.a == 2) ? "R4" : "R7";
      e.tb = "R6";
      e.ts = st ? "R8" : "R10";
      e.why = why;
      sbq.push_back(e);
      @(posedge clk);
      m_wb  = m_mem;
      m_mem = m_ex;
      m_ex  = st ? '{default: 0} : c;
    end while (st);
  endtask

  task automatic drain();
    repeat (3) feed(32'h0, "drain R10");
  endtask

  // monitor: compare one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check($sformatf("%s fwd_a [%s]", e.ta, e.why), int'(fwd_a_sel), e.a);
        check($sformatf("%s fwd_b [%s]", e.tb, e.why), int'(fwd_b_sel), e.b);
        check($sformatf("%s pc_hold [%s]", e.ts, e.why), int'(pc_hold), int'(e.st));
        check($sformatf("%s ifid_hold [%s]", e.ts, e.why), int'(ifid_hold), int'(e.st));
        check($sformatf("%s nop_insert [%s]", e.ts, e.why), int'(nop_insert), int'(e.st));
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #50000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    m_ex = '{default: 0}; m_mem = '{default: 0}; m_wb = '{default: 0};
    repeat (2) @(negedge clk);
    #1;
    check("R2 fwd_a in reset", int'(fwd_a_sel), 0);
    check("R2 stall in reset", int'(pc_hold | ifid_hold | nop_insert), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 fwd_b after reset", int'(fwd_b_sel), 0);
    check("R2 stall after reset", int'(pc_hold | ifid_hold | nop_insert), 0);

    // R11 / R3: ALU producer then consumer of its rd on S
    feed(mk_r(1, 2, 3, 1), "R11 producer");
    feed(mk_r(1, 1, 5, 4), "R11 consumer");
    drain();
    // R4: producer, unrelated, consumer
    feed(mk_r(1, 0, 0, 2), "R4 producer");
    feed(mk_r(1, 6, 6, 5), "R4 gap");
    feed(mk_r(1, 2, 0, 3), "R4 consumer");
    drain();
    // R5: two writers of the same register
    feed(mk_r(1, 0, 0, 3), "R5 older");
    feed(mk_r(1, 0, 0, 3), "R5 younger");
    feed(mk_r(1, 3, 3, 4), "R5 consumer");
    drain();
    // R6: operand B for store and branch; none for immediate ALU
    feed(mk_i(2, 0, 5, 16'h1234), "R6 imm producer");
    feed(mk_i(4, 1, 5, 0), "R6 store reads T");
    feed(mk_i(5, 0, 5, 0), "R6 branch reads T");
    feed(mk_i(2, 5, 5, 0), "R6 imm ALU T not read");
    drain();
    // R7: non-writers, and I-type writes T not 21:19
    feed(mk_i(4, 0, 6, 0), "R7 store no write");
    feed(mk_r(1, 6, 6, 1), "R7 consumer of store");
    feed({4'd2, 3'd0, 3'd7, 3'd2, 19'd0}, "R7 imm writes T");
    feed(mk_r(1, 2, 7, 1), "R7 S=bits21:19 no fwd T fwd");
    feed(mk_r(6, 0, 0, 0), "R7 jump no write");
    feed(mk_r(1, 0, 0, 1), "R7 after jump");
    drain();
    // R8 / R9: load-use on S, on T; load then load
    feed(mk_i(3, 0, 4, 8), "R8 load");
    feed(mk_r(1, 4, 0, 5), "R8 R9 consumer S");
    drain();
    feed(mk_i(3, 1, 5, 0), "R8 load");
    feed(mk_i(4, 0, 5, 0), "R8 R9 store T");
    feed(mk_i(3, 5, 1, 0), "R8 load chain");
    feed(mk_i(3, 1, 2, 0), "R8 R9 load uses load");
    drain();
    // R10: things that must not stall after a load
    feed(mk_i(3, 0, 3, 0), "R10 load");
    feed(mk_r(6, 3, 3, 3), "R10 jump");
    feed(mk_i(3, 0, 3, 0), "R10 load");
    feed(mk_i(2, 1, 3, 0), "R10 imm T not read");
    feed(mk_i(3, 0, 3, 0), "R10 load");
    feed({4'hF, 3'd3, 3'd3, 3'd3, 19'd0}, "R10 reserved opcode");
    feed(mk_i(3, 0, 3, 0), "R10 load");
    feed(mk_r(1, 2, 4, 3), "R10 no field match");
    drain();
    // R1: highest register indices in every field
    feed(mk_r(1, 7, 7, 7), "R1 all fields 7");
    feed(mk_r(1, 7, 7, 7), "R1 all fields 7");
    drain();
    // R2: reset discards a recorded load
    feed(mk_i(3, 0, 4, 0), "R2 load before reset");
    @(negedge clk);
    rst_n = 1'b0;
    ifid_instr = mk_r(1, 4, 4, 1);
    #1;
    check("R2 no stall after reset clears load", int'(pc_hold | ifid_hold | nop_insert), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_ex = '{default: 0}; m_mem = '{default: 0}; m_wb = '{default: 0};
    #1;
    check("R2 no stall after release", int'(nop_insert), 0);
    check("R2 fwd_a after release", int'(fwd_a_sel), 0);
    repeat (3) @(negedge clk);
    #2;
    summary();
    $finish;
  end

endmodule